// File: doc/BRIEF.md
# Coprocessor reset and halt control

This block sits on the main processor's bus and owns the control word that drives a secondary processor's reset and halt inputs and raises interrupt requests towards it. A byte or word write to the control byte decides whether the secondary core is released from reset, held off the bus, or both. Reset is signalled as a single-cycle pulse, and only when the release bit goes from 0 to 1. Clearing the release bit always forces halt and loads a fixed pattern into the stored bits. The stored bus-request bit reads 0 if the secondary core has stopped itself at the moment of the write.

Each time the halt state changes, the block decides again whether the main side may reach the secondary processor's program RAM. When access is granted while a DMA into that RAM is running, the DMA is paused. When access is revoked, a paused DMA resumes. Writing 1 to the interrupt-flag bit raises a level-2 request, but only if that level is enabled. Writing 0 to the flag does nothing. The level presented to the secondary core is the highest enabled pending level. Levels from other sources are included through an input vector. The secondary side clears the level-2 request with an acknowledge input.

The register block decodes one word at offset 0:
- The even byte holds the interrupt flag in bit 0.
- The odd byte holds the control bits.
- All other offsets are ignored.

Top module: `coproc_ctl`

## Requirements
- R1: After reset, the read word is 0x0002 (release = 0, bus-request = 1, flag = 0), halt is 1, the RAM grant is 1, DMA pause is 0, the interrupt level is 0 and there is no reset pulse.
- R2: A control write with bit 0 = 1 produces a reset pulse exactly one cycle wide, and only if the stored release bit was 0. Writing 1 again produces no pulse.
- R3: A control write with bit 0 = 1 sets halt equal to written bit 1, and the stored bits (bit 1 = bus-request, bit 0 = release) become the written two bits.
- R4: A control write with bit 0 = 0 asserts halt and stores release = 0, bus-request = 1, whatever written bit 1 was.
- R5: If the self-stopped input is 1 during a control write, the stored bus-request bit becomes 0. Halt is still set as in R3 and R4.
- R6: The RAM grant is reloaded from the new stored bus-request bit only on a write that changes halt. A write that leaves halt unchanged keeps the grant as it was.
- R7: When the grant is reloaded to 1 while the DMA-active input is 1, DMA pause becomes 1. When the grant is reloaded to 0, DMA pause becomes 0.
- R8: Writing flag = 1 sets the level-2 pending request only if enable-mask bit 2 is 1. Writing flag = 0, or writing 1 while mask bit 2 is 0, leaves it unchanged.
- R9: The interrupt level output is the highest index i in 1..7 for which bit i of (pending AND mask) is set, or 0 if none. Pending bit 2 is the local request OR external source bit 2. The level is registered from the next-state pending and the current mask.
- R10: The acknowledge input clears the level-2 request. A set on the same cycle wins over the acknowledge.
- R11: For byte writes, offset 0 carries the flag in data bit 0 and offset 1 carries the control bits in data bits 1:0. A word write at offset 0 carries the flag in bit 8 and the control bits in bits 1:0. Writes to any other offset have no effect.
- R12: A read returns, one cycle after the read strobe, the word {flag at bit 8, bus-request at bit 1, release at bit 0} for offsets 0 and 1, and 0 for all other offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 1 | 1 = word write, 0 = byte write |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 16 | Write data (byte writes use bits 7:0) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte offset of the read |
| rd_data | output | 16 | Registered read word |
| sub_stopped | input | 1 | Secondary processor has stopped itself |
| irq_mask | input | NUM_LVL | Interrupt enable mask, bit i enables level i |
| ext_pend | input | NUM_LVL | Pending requests from other sources, by level |
| irq_ack | input | 1 | Clears the level-2 request |
| dma_active | input | 1 | A DMA into program RAM is running |
| sub_reset_pulse | output | 1 | One-cycle reset pulse to the secondary core |
| sub_halt | output | 1 | Halt level to the secondary core |
| sub_irq_level | output | LVL_W | Interrupt level to the secondary core |
| prg_grant | output | 1 | Main side may access program RAM |
| dma_pause | output | 1 | Pause the program-RAM DMA |

## Verification
The bench targets the edge condition on the reset pulse: a design that pulsed on level instead of on the 0-to-1 edge would pulse on a repeated write of 1. It also checks the forced pattern after release is cleared: a design that kept written bit 1 would read 0x0000 after writing 0x00. It covers the self-stopped override, where a design that ignored it would grant RAM access while the core is not yielding the bus. It also covers a write that clears release while already halted: a design that reloaded the grant on every write, instead of only when halt changes, would change a grant that must hold. Finally, the bench checks mask gating, set-over-acknowledge priority and the level priority encoder, where a design that got the priority wrong would report a lower level while a higher one is enabled.

// File: rtl/coproc_ctl_pkg.sv
package coproc_ctl_pkg;
  localparam int CTL_REL_BIT  = 0;
  localparam int CTL_BREQ_BIT = 1;
  localparam int OWN_IRQ_LVL  = 2;
  localparam int WORD_FLAG_BIT = 8;

  typedef struct packed {
    logic breq;
    logic rel;
  } ctl_bits_t;
endpackage

// File: rtl/coproc_ctl_regs.sv
module coproc_ctl_regs
  import coproc_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      we,
  input  logic [1:0] wd,
  input  logic      stopped,
  output ctl_bits_t ctl_q,
  output logic      halt_q,
  output logic      pulse_q,
  output logic      halt_chg,
  output logic      breq_nxt
);
  ctl_bits_t ctl_n;
  logic      halt_n;
  logic      pulse_n;

  always_comb begin
    ctl_n   = ctl_q;
    halt_n  = halt_q;
    pulse_n = 1'b0;
    if (we) begin
      if (wd[CTL_REL_BIT]) begin
        pulse_n    = !ctl_q.rel;
        halt_n     = wd[CTL_BREQ_BIT];
        ctl_n.rel  = 1'b1;
        ctl_n.breq = wd[CTL_BREQ_BIT];
      end else begin
        halt_n     = 1'b1;
        ctl_n.rel  = 1'b0;
        ctl_n.breq = 1'b1;
      end
      if (stopped) ctl_n.breq = 1'b0;
    end
  end

  assign halt_chg = we && (halt_n != halt_q);
  assign breq_nxt = ctl_n.breq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '{breq: 1'b1, rel: 1'b0};
      halt_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_n;
      halt_q  <= halt_n;
      pulse_q <= pulse_n;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pulse_q |=> !pulse_q); // R2
  AST_PULSE_FROM_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q.rel) |-> pulse_q); // R2
  AST_UNRELEASED_HALTS: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.rel |-> halt_q); // R4
  AST_STOPPED_NO_BREQ: assert property (@(posedge clk) disable iff (rst)
    (we && stopped) |=> !ctl_q.breq); // R5
endmodule

// File: rtl/coproc_ctl_grant.sv
module coproc_ctl_grant (
  input  logic clk,
  input  logic rst,
  input  logic halt_chg,
  input  logic breq_nxt,
  input  logic dma_active,
  input  logic halt_q,
  output logic grant_q,
  output logic pause_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b1;
      pause_q <= 1'b0;
    end else if (halt_chg) begin
      grant_q <= breq_nxt;
      if (breq_nxt) pause_q <= pause_q | dma_active;
      else          pause_q <= 1'b0;
    end
  end

  AST_GRANT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    $stable(halt_q) |-> $stable(grant_q)); // R6
  AST_PAUSE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    pause_q |-> grant_q); // R7
endmodule

// File: rtl/coproc_ctl_irq.sv
module coproc_ctl_irq
  import coproc_ctl_pkg::*;
#(
  parameter int LVL_W = 3,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_we,
  input  logic               set_d,
  input  logic               ack,
  input  logic [NUM_LVL-1:0] mask,
  input  logic [NUM_LVL-1:0] ext_pend,
  output logic               own_q,
  output logic [LVL_W-1:0]   level_q
);
  logic               own_n;
  logic [NUM_LVL-1:0] hit;
  logic [LVL_W-1:0]   level_n;

  always_comb begin
    own_n = own_q;
    if (ack) own_n = 1'b0;
    if (set_we && set_d && mask[OWN_IRQ_LVL]) own_n = 1'b1;
  end

  assign hit[0] = 1'b0;
  for (genvar i = 1; i < NUM_LVL; i++) begin : g_hit
    if (i == OWN_IRQ_LVL) begin : g_own
      assign hit[i] = (own_n | ext_pend[i]) & mask[i];
    end else begin : g_ext
      assign hit[i] = ext_pend[i] & mask[i];
    end
  end

  always_comb begin
    level_n = '0;
    for (int i = 1; i < NUM_LVL; i++) begin
      if (hit[i]) level_n = LVL_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q   <= 1'b0;
      level_q <= '0;
    end else begin
      own_q   <= own_n;
      level_q <= level_n;
    end
  end

  AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(own_q) |-> $past(mask[OWN_IRQ_LVL])); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !set_we) |=> !own_q); // R10
  AST_OWN_LEVEL_SEEN: assert property (@(posedge clk) disable iff (rst)
    (own_n && mask[OWN_IRQ_LVL]) |=> (level_q >= LVL_W'(OWN_IRQ_LVL))); // R9
endmodule

// File: rtl/coproc_ctl.sv
module coproc_ctl
  import coproc_ctl_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LVL_W  = 3,
  localparam int NUM_LVL = 1 << LVL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_word,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [15:0]        wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [15:0]        rd_data,
  input  logic               sub_stopped,
  input  logic [NUM_LVL-1:0] irq_mask,
  input  logic [NUM_LVL-1:0] ext_pend,
  input  logic               irq_ack,
  input  logic               dma_active,
  output logic               sub_reset_pulse,
  output logic               sub_halt,
  output logic [LVL_W-1:0]   sub_irq_level,
  output logic               prg_grant,
  output logic               dma_pause
);
  logic      wr_hit, rd_hit;
  logic      ctl_we, flag_we, flag_d;
  ctl_bits_t ctl_q;
  logic      halt_chg, breq_nxt, own_q;
  logic      unused_bits;

  assign wr_hit  = wr_en && (wr_addr[ADDR_W-1:1] == '0);
  assign rd_hit  = (rd_addr[ADDR_W-1:1] == '0);
  assign ctl_we  = wr_hit && (wr_word || wr_addr[0]);
  assign flag_we = wr_hit && (wr_word || !wr_addr[0]);
  assign flag_d  = wr_word ? wr_data[WORD_FLAG_BIT] : wr_data[0];
  assign unused_bits = ^{wr_data[15:9], wr_data[7:2], rd_addr[0]};

  coproc_ctl_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .we       (ctl_we),
    .wd       (wr_data[1:0]),
    .stopped  (sub_stopped),
    .ctl_q    (ctl_q),
    .halt_q   (sub_halt),
    .pulse_q  (sub_reset_pulse),
    .halt_chg (halt_chg),
    .breq_nxt (breq_nxt)
  );

  coproc_ctl_grant u_grant (
    .clk        (clk),
    .rst        (rst),
    .halt_chg   (halt_chg),
    .breq_nxt   (breq_nxt),
    .dma_active (dma_active),
    .halt_q     (sub_halt),
    .grant_q    (prg_grant),
    .pause_q    (dma_pause)
  );

  coproc_ctl_irq #(.LVL_W(LVL_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .set_we   (flag_we),
    .set_d    (flag_d),
    .ack      (irq_ack),
    .mask     (irq_mask),
    .ext_pend (ext_pend),
    .own_q    (own_q),
    .level_q  (sub_irq_level)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_hit ? {7'b0, own_q, 6'b0, ctl_q.breq, ctl_q.rel} : 16'h0000;
    end
  end

  AST_RD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
    ({rd_data[15:9], rd_data[7:2]} == '0)); // R12
endmodule

// File: tb/tb_coproc_ctl.sv
module tb_coproc_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int LVL_W  = 3;
  localparam int NUM_LVL = 1 << LVL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_word = 0, rd_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic sub_stopped = 0, irq_ack = 0, dma_active = 0;
  logic [NUM_LVL-1:0] irq_mask = '0, ext_pend = '0;
  logic sub_reset_pulse, sub_halt, prg_grant, dma_pause;
  logic [LVL_W-1:0] sub_irq_level;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coproc_ctl #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .sub_stopped(sub_stopped), .irq_mask(irq_mask), .ext_pend(ext_pend),
    .irq_ack(irq_ack), .dma_active(dma_active), .sub_reset_pulse(sub_reset_pulse),
    .sub_halt(sub_halt), .sub_irq_level(sub_irq_level), .prg_grant(prg_grant),
    .dma_pause(dma_pause)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic word, input int addr, input int data);
    @(negedge clk);
    wr_en = 1; wr_word = word; wr_addr = ADDR_W'(addr); wr_data = 16'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int addr, output int val);
    @(negedge clk);
    rd_en = 1; rd_addr = ADDR_W'(addr);
    @(negedge clk);
    rd_en = 0;
    val = int'(rd_data);
  endtask

  task automatic t_reset_state();
    int v;
    chk("R1", "halt", sub_halt, 1);
    chk("R1", "grant", prg_grant, 1);
    chk("R1", "pause", dma_pause, 0);
    chk("R1", "level", sub_irq_level, 0);
    chk("R1", "pulse", sub_reset_pulse, 0);
    rd(0, v); chk("R1", "read word", v, 16'h0002);
  endtask

  task automatic t_release_and_edge();
    int v;
    wr(0, 1, 8'h01);
    chk("R2", "pulse on 0->1", sub_reset_pulse, 1);
    chk("R3", "halt released", sub_halt, 0);
    chk("R6", "grant revoked", prg_grant, 0);
    @(negedge clk);
    chk("R2", "pulse one cycle", sub_reset_pulse, 0);
    rd(1, v); chk("R3", "stored 01", v, 16'h0001);
    wr(0, 1, 8'h01);
    chk("R2", "no pulse on repeat", sub_reset_pulse, 0);
  endtask

  task automatic t_halt_and_dma();
    int v;
    dma_active = 1;
    wr(0, 1, 8'h03);
    chk("R3", "halt set", sub_halt, 1);
    chk("R6", "grant on halt", prg_grant, 1);
    chk("R7", "dma paused", dma_pause, 1);
    rd(0, v); chk("R3", "stored 03", v, 16'h0003);
    wr(0, 1, 8'h01);
    chk("R6", "grant off", prg_grant, 0);
    chk("R7", "dma resumed", dma_pause, 0);
    dma_active = 0;
  endtask

  task automatic t_clear_release();
    int v;
    wr(0, 1, 8'h00);
    chk("R4", "halt forced", sub_halt, 1);
    rd(0, v); chk("R4", "forced pattern", v, 16'h0002);
    chk("R7", "no pause without dma", dma_pause, 0);
    wr(0, 1, 8'h01);
    chk("R2", "pulse after clear", sub_reset_pulse, 1);
  endtask

  task automatic t_self_stopped();
    int v;
    sub_stopped = 1;
    wr(0, 1, 8'h03);
    sub_stopped = 0;
    chk("R5", "halt set", sub_halt, 1);
    chk("R6", "grant from breq 0", prg_grant, 0);
    rd(0, v); chk("R5", "breq reads 0", v, 16'h0001);
    wr(0, 1, 8'h02);
    chk("R6", "grant held, halt unchanged", prg_grant, 0);
    rd(0, v); chk("R4", "forced pattern again", v, 16'h0002);
  endtask

  task automatic t_ignored_addr();
    int v;
    wr(0, 3, 8'h01);
    chk("R11", "other offset no pulse", sub_reset_pulse, 0);
    chk("R11", "other offset halt", sub_halt, 1);
    rd(0, v); chk("R11", "other offset no change", v, 16'h0002);
    rd(4, v); chk("R12", "other offset reads 0", v, 0);
  endtask

  task automatic t_irq();
    int v;
    irq_mask = '0;
    wr(0, 0, 8'h01);
    rd(0, v); chk("R8", "masked set ignored", v, 16'h0002);
    irq_mask = 8'h04;
    wr(0, 0, 8'h01);
    chk("R9", "level 2", sub_irq_level, 2);
    rd(0, v); chk("R12", "flag reads at bit 8", v, 16'h0102);
    wr(0, 0, 8'h00);
    rd(0, v); chk("R8", "write 0 ignored", v, 16'h0102);
    ext_pend = 8'h20; irq_mask = 8'h24;
    @(negedge clk);
    chk("R9", "higher level wins", sub_irq_level, 5);
    irq_mask = 8'h04;
    @(negedge clk);
    chk("R9", "masked higher level", sub_irq_level, 2);
    ext_pend = '0;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    chk("R10", "ack clears level", sub_irq_level, 0);
    rd(0, v); chk("R10", "ack clears flag", v, 16'h0002);
    @(negedge clk);
    wr_en = 1; wr_word = 1; wr_addr = '0; wr_data = 16'h0103; irq_ack = 1;
    @(negedge clk);
    wr_en = 0; irq_ack = 0;
    chk("R10", "set beats ack", sub_irq_level, 2);
    chk("R11", "word write control", sub_halt, 1);
    rd(0, v); chk("R11", "word write both lanes", v, 16'h0103);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset_state();
    t_release_and_edge();
    t_halt_and_dma();
    t_clear_release();
    t_self_stopped();
    t_ignored_addr();
    t_irq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule